// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor core. On each issued operation it combines the working-register value with a second operand. That operand is either a file-register value or an immediate literal. The block computes an 8-bit result and says where that result should be written. It also updates a five-flag status register: negative, signed overflow, carry, zero and nibble carry. An 8x8 unsigned multiply does not produce a normal result. It loads a separate 16-bit product register instead.

The enclosing core decodes instructions and presents one operation per cycle with `valid_i` high. The result and its write enables are combinational from the inputs and the current flags. The status and product registers update on the next rising clock edge. Add and subtract can be chained through the carry flag for multi-byte arithmetic. Subtraction exists in three forms: operand minus working register, the same with borrow, and a reversed form with borrow. Negate, rotates without carry, nibble swap and the three bitwise operations complete the set.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, `status_o` and `prod_o` are zero. The status bit positions are C=bit 0, DC=bit 1, Z=bit 2, OV=bit 3, N=bit 4.
- R2: Op 0 gives `wreg_i + opnd_i`. Op 1 gives `wreg_i + opnd_i + C`. In both, C is set on a carry out of bit 7.
- R3: Op 2 gives `opnd_i - wreg_i`. Op 3 gives `opnd_i - wreg_i - borrow`, where borrow is NOT C. After any subtract, C is 1 exactly when no borrow occurred.
- R4: Op 4 is the reversed subtract with borrow: `wreg_i - opnd_i - (NOT C)`. It sets flags in the same way as R3.
- R5: Ops 0 to 4 and 11 update all five flags. DC is the carry out of bit 3, or NOT borrow out of bit 3 for subtracts. OV is two's-complement signed overflow. N is result bit 7. Z is set when the result is zero.
- R6: Ops 5 (AND), 6 (OR) and 7 (XOR) combine `wreg_i` with `opnd_i` bitwise. They update only N and Z, and leave C, DC and OV unchanged.
- R7: Op 8 rotates `opnd_i` left by one, with bit 7 moving to bit 0. Op 9 rotates it right by one, with bit 0 moving to bit 7. Both update only N and Z. Op 10 exchanges bits [7:4] of `opnd_i` with bits [3:0] and changes no flag.
- R8: Op 11 gives the two's complement `0 - opnd_i` and sets flags as a subtract from zero.
- R9: Op 12 loads `prod_o` with the 16-bit unsigned product `wreg_i * opnd_i`. It asserts neither write enable and changes no flag.
- R10: An operation with a result (ops 0 to 11) asserts `wreg_we_o` when `lit_i` is 1 or `dest_i` is 0. It asserts `file_we_o` when `lit_i` is 0 and `dest_i` is 1. At most one write enable is high at a time.
- R11: When `valid_i` is low, or when op is 13 to 15, neither write enable is asserted and `status_o` and `prod_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Operation code |
| lit_i | input | 1 | Second operand is a literal; result goes to the working register |
| dest_i | input | 1 | Register-operand destination: 0 working register, 1 file register |
| wreg_i | input | 8 | Working-register value |
| opnd_i | input | 8 | File-register value or literal |
| result_o | output | 8 | Operation result |
| wreg_we_o | output | 1 | Write result to the working register |
| file_we_o | output | 1 | Write result to the file register |
| status_o | output | 5 | Status flags {N, OV, Z, DC, C} |
| prod_o | output | 16 | Product register, high byte in [15:8] |

## Verification
The hardest cases to reach are the chained forms. Their results depend on a carry flag that an earlier operation left behind, so they cannot be set up in a single cycle. For each table vector, the bench first issues an add that forces C and DC to a known 0 or 1, then issues the vector under test. This also shows that the logic ops and rotates carry C, DC and OV through unchanged. A long random sequence then runs with no setup, so every chained subtract and add picks up whatever carry the previous random operation produced. The bench tracks that carry with its own flag model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned ST_C  = 0;
  localparam int unsigned ST_DC = 1;
  localparam int unsigned ST_Z  = 2;
  localparam int unsigned ST_OV = 3;
  localparam int unsigned ST_N  = 4;
  localparam int unsigned ST_W  = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_SUBR = 4'd4,
    OP_AND  = 4'd5,
    OP_IOR  = 4'd6,
    OP_XOR  = 4'd7,
    OP_RLN  = 4'd8,
    OP_RRN  = 4'd9,
    OP_SWAP = 4'd10,
    OP_NEG  = 4'd11,
    OP_MUL  = 4'd12
  } op_e;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NIB = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          ov_o
);
  logic [DW:0]  full;
  logic [NIB:0] low;

  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci_i};
  assign low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, ci_i};
  assign sum_o = full[DW-1:0];
  assign c_o   = full[DW];
  assign dc_o  = low[NIB];
  // signed overflow: like-signed inputs, result sign differs
  assign ov_o  = (a_i[DW-1] == b_i[DW-1]) && (full[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/acc_alu_bitop.sv
module acc_alu_bitop
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned HALF = DW / 2;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_IOR:  res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_RLN:  res_o = {b_i[DW-2:0], b_i[DW-1]};
      OP_RRN:  res_o = {b_i[0], b_i[DW-1:1]};
      OP_SWAP: res_o = {b_i[HALF-1:0], b_i[DW-1:HALF]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] p_o
);
  assign p_o = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic            lit_i,
  input  logic            dest_i,
  input  logic [DW-1:0]   wreg_i,
  input  logic [DW-1:0]   opnd_i,
  output logic [DW-1:0]   result_o,
  output logic            wreg_we_o,
  output logic            file_we_o,
  output logic [ST_W-1:0] status_o,
  output logic [2*DW-1:0] prod_o
);
  localparam int unsigned NIB = DW / 2;
  localparam int unsigned PW  = 2 * DW;

  op_e             op;
  logic [DW-1:0]   add_a, add_b, add_s, bit_r;
  logic            add_ci, add_c, add_dc, add_ov;
  logic [PW-1:0]   mul_p, prod_q;
  logic            is_arith, is_nz, is_mul, has_res;
  logic [ST_W-1:0] st_q, st_d;

  assign op = op_e'(op_i);

  // operand steering: every subtract is x + ~y + carry-in
  always_comb begin
    add_a    = wreg_i;
    add_b    = opnd_i;
    add_ci   = 1'b0;
    is_arith = 1'b0;
    is_nz    = 1'b0;
    is_mul   = 1'b0;
    has_res  = 1'b1;
    unique case (op)
      OP_ADD:  is_arith = 1'b1;
      OP_ADDC: begin is_arith = 1'b1; add_ci = st_q[ST_C]; end
      OP_SUB:  begin is_arith = 1'b1; add_a = opnd_i; add_b = ~wreg_i; add_ci = 1'b1; end
      OP_SUBB: begin is_arith = 1'b1; add_a = opnd_i; add_b = ~wreg_i; add_ci = st_q[ST_C]; end
      OP_SUBR: begin is_arith = 1'b1; add_b = ~opnd_i; add_ci = st_q[ST_C]; end
      OP_NEG:  begin is_arith = 1'b1; add_a = '0; add_b = ~opnd_i; add_ci = 1'b1; end
      OP_AND, OP_IOR, OP_XOR, OP_RLN, OP_RRN: is_nz = 1'b1;
      OP_SWAP: ;
      OP_MUL:  begin is_mul = 1'b1; has_res = 1'b0; end
      default: has_res = 1'b0;
    endcase
  end

  acc_alu_adder #(.DW(DW), .NIB(NIB)) u_add (
    .a_i(add_a), .b_i(add_b), .ci_i(add_ci),
    .sum_o(add_s), .c_o(add_c), .dc_o(add_dc), .ov_o(add_ov)
  );

  acc_alu_bitop #(.DW(DW)) u_bit (
    .op_i(op), .a_i(wreg_i), .b_i(opnd_i), .res_o(bit_r)
  );

  acc_alu_mul #(.DW(DW)) u_mul (
    .a_i(wreg_i), .b_i(opnd_i), .p_o(mul_p)
  );

  assign result_o  = is_arith ? add_s : (has_res ? bit_r : '0);
  assign wreg_we_o = valid_i && has_res && (lit_i || !dest_i);
  assign file_we_o = valid_i && has_res && !lit_i && dest_i;

  always_comb begin
    st_d = st_q;
    if (valid_i && (is_arith || is_nz)) begin
      st_d[ST_N] = result_o[DW-1];
      st_d[ST_Z] = ~|result_o;
      if (is_arith) begin
        st_d[ST_C]  = add_c;
        st_d[ST_DC] = add_dc;
        st_d[ST_OV] = add_ov;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      prod_q <= '0;
    end else begin
      st_q <= st_d;
      if (valid_i && is_mul) prod_q <= mul_p;
    end
  end

  assign status_o = st_q;
  assign prod_o   = prod_q;

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(status_o) && $stable(prod_o));

  a_r10_single_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wreg_we_o, file_we_o}));

  a_r10_lit_to_w: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lit_i) |-> !file_we_o);

  a_r9_mul_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL) |=> $stable(status_o));

  a_r9_mul_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL) |-> !wreg_we_o && !file_we_o);

  a_r7_rot_keep_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_RLN || op == OP_RRN)) |=> status_o[ST_C] == $past(status_o[ST_C]));

  a_r6_logic_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_AND || op == OP_IOR || op == OP_XOR))
      |=> {status_o[ST_OV], status_o[ST_DC], status_o[ST_C]} ==
          $past({status_o[ST_OV], status_o[ST_DC], status_o[ST_C]}));

  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_arith) |=> status_o[ST_Z] == ($past(result_o) == '0));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, valid_i, lit_i, dest_i;
  logic [3:0]  op_i;
  logic [7:0]  wreg_i, opnd_i, result_o;
  logic        wreg_we_o, file_we_o;
  logic [4:0]  status_o;
  logic [15:0] prod_o;

  acc_alu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .lit_i(lit_i), .dest_i(dest_i), .wreg_i(wreg_i), .opnd_i(opnd_i),
    .result_o(result_o), .wreg_we_o(wreg_we_o), .file_we_o(file_we_o),
    .status_o(status_o), .prod_o(prod_o)
  );

  int checks = 0;
  int errors = 0;
  logic [4:0]  m_st;
  logic [15:0] m_prod;

  // {op, w, b, carry before, result, status after}
  localparam logic [33:0] VEC [19] = '{
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 5'h1A},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 5'h07},
    {4'd1,  8'h80, 8'h80, 1'b1, 8'h01, 5'h09},
    {4'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 5'h02},
    {4'd2,  8'h03, 8'h05, 1'b0, 8'h02, 5'h03},
    {4'd2,  8'h05, 8'h03, 1'b1, 8'hFE, 5'h10},
    {4'd2,  8'h01, 8'h80, 1'b0, 8'h7F, 5'h09},
    {4'd3,  8'h00, 8'h00, 1'b0, 8'hFF, 5'h10},
    {4'd3,  8'h0F, 8'h10, 1'b1, 8'h01, 5'h01},
    {4'd4,  8'h10, 8'h10, 1'b1, 8'h00, 5'h07},
    {4'd4,  8'h00, 8'h01, 1'b0, 8'hFE, 5'h10},
    {4'd11, 8'h00, 8'h80, 1'b0, 8'h80, 5'h1A},
    {4'd11, 8'h55, 8'h00, 1'b0, 8'h00, 5'h07},
    {4'd5,  8'hF0, 8'h0F, 1'b1, 8'h00, 5'h07},
    {4'd7,  8'hFF, 8'h7F, 1'b0, 8'h80, 5'h10},
    {4'd6,  8'h00, 8'h00, 1'b1, 8'h00, 5'h07},
    {4'd8,  8'h00, 8'h81, 1'b1, 8'h03, 5'h03},
    {4'd9,  8'h00, 8'h01, 1'b0, 8'h80, 5'h10},
    {4'd10, 8'h00, 8'hA5, 1'b1, 8'h5A, 5'h07}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:        return "R2";
      2, 3:        return "R3";
      4:           return "R4";
      5, 6, 7:     return "R6";
      8, 9, 10:    return "R7";
      11:          return "R8";
      12:          return "R9";
      default:     return "R11";
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // independent integer model; updates m_st / m_prod for the next edge
  task automatic model(input int op, input int w, input int b, input bit lit,
                       input bit dest, input bit vld,
                       output int r, output int wwe, output int fwe);
    int c, brw, s, lo, sg;
    bit arith, nz, wr;
    logic [4:0] ns;
    c = int'(m_st[0]); brw = 1 - c;
    r = 0; arith = 0; nz = 0; wr = 1; s = 0; lo = 0; sg = 0;
    ns = m_st;
    case (op)
      0:  begin arith = 1; s = w + b;     lo = (w & 15) + (b & 15);     sg = sx(w) + sx(b); end
      1:  begin arith = 1; s = w + b + c; lo = (w & 15) + (b & 15) + c; sg = sx(w) + sx(b) + c; end
      2:  begin arith = 1; s = b - w;       lo = (b & 15) - (w & 15);       sg = sx(b) - sx(w); end
      3:  begin arith = 1; s = b - w - brw; lo = (b & 15) - (w & 15) - brw; sg = sx(b) - sx(w) - brw; end
      4:  begin arith = 1; s = w - b - brw; lo = (w & 15) - (b & 15) - brw; sg = sx(w) - sx(b) - brw; end
      11: begin arith = 1; s = 0 - b;       lo = 0 - (b & 15);             sg = 0 - sx(b); end
      5:  begin nz = 1; r = w & b; end
      6:  begin nz = 1; r = w | b; end
      7:  begin nz = 1; r = w ^ b; end
      8:  begin nz = 1; r = ((b << 1) | (b >> 7)) & 255; end
      9:  begin nz = 1; r = ((b >> 1) | (b << 7)) & 255; end
      10: r = ((b << 4) | (b >> 4)) & 255;
      12: begin wr = 0; if (vld) m_prod = 16'(w * b); end
      default: wr = 0;
    endcase
    if (arith) begin
      r = s & 255;
      if (op <= 1) begin ns[0] = (s > 255); ns[1] = (lo > 15); end
      else         begin ns[0] = (s >= 0);  ns[1] = (lo >= 0); end
      ns[3] = (sg < -128) || (sg > 127);
    end
    if (arith || nz) begin
      ns[4] = (r > 127);
      ns[2] = (r == 0);
    end
    wwe = (vld && wr && (lit || !dest)) ? 1 : 0;
    fwe = (vld && wr && !lit && dest) ? 1 : 0;
    if (vld) m_st = ns;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input int op, input int w, input int b, input bit lit,
                       input bit dest, input bit vld,
                       input bit use_tab, input int t_res, input int t_st);
    int er, ew, ef;
    string tg;
    model(op, w, b, lit, dest, vld, er, ew, ef);
    tg = vld ? tag_of(op) : "R11";
    valid_i = vld; op_i = 4'(op); wreg_i = 8'(w); opnd_i = 8'(b);
    lit_i = lit; dest_i = dest;
    #2;
    if (vld && op < 12) chk(tg, int'(result_o), use_tab ? t_res : er);
    chk("R10", int'(wreg_we_o), ew);
    chk("R10", int'(file_we_o), ef);
    @(negedge clk_i);
    if (use_tab) chk((op <= 4 || op == 11) ? "R5" : tg, int'(status_o), t_st);
    chk(tg, int'(status_o), int'(m_st));
    chk(tg, int'(prod_o), int'(m_prod));
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; lit_i = 1'b0; dest_i = 1'b0;
    wreg_i = '0; opnd_i = '0;
    m_st = '0; m_prod = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", int'(status_o), 0);
    chk("R1", int'(prod_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: a setup add forces the carry, then the vector runs
    foreach (VEC[i]) begin
      if (VEC[i][13]) apply(0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, 0);
      else            apply(0, 8'h00, 8'h00, 0, 0, 1, 0, 0, 0);
      apply(int'(VEC[i][33:30]), int'(VEC[i][29:22]), int'(VEC[i][21:14]),
            0, 0, 1, 1, int'(VEC[i][12:5]), int'(VEC[i][4:0]));
    end

    // R9 multiply corners
    apply(12, 8'hFF, 8'hFF, 1, 0, 1, 0, 0, 0);
    chk("R9", int'(prod_o), 16'hFE01);
    apply(12, 8'h80, 8'h7F, 1, 1, 1, 0, 0, 0);
    chk("R9", int'(prod_o), 16'h3F80);
    // R10 destination select
    apply(0, 8'h01, 8'h02, 0, 1, 1, 0, 0, 0);
    apply(0, 8'h01, 8'h02, 1, 1, 1, 0, 0, 0);
    apply(5, 8'hFF, 8'h0F, 0, 1, 1, 0, 0, 0);
    // R11 idle and reserved codes leave state untouched
    apply(0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, 0);
    apply(12, 8'h12, 8'h34, 0, 0, 0, 0, 0, 0);
    apply(2, 8'h12, 8'h34, 0, 1, 0, 0, 0, 0);
    apply(13, 8'hFF, 8'hFF, 0, 1, 1, 0, 0, 0);
    apply(15, 8'h00, 8'h00, 1, 0, 1, 0, 0, 0);
    chk("R11", int'(status_o), 5'h07);

    // random chained sequence: carry state flows from op to op
    for (int k = 0; k < 3000; k++) begin
      int op, w, b;
      op = $urandom_range(0, 15);
      case ($urandom_range(0, 5))
        0: w = 0; 1: w = 8'h7F; 2: w = 8'h80; 3: w = 8'hFF;
        default: w = $urandom_range(0, 255);
      endcase
      case ($urandom_range(0, 5))
        0: b = 0; 1: b = 8'h7F; 2: b = 8'h80; 3: b = 8'hFF;
        default: b = $urandom_range(0, 255);
      endcase
      apply(op, w, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 7) != 0), 0, 0, 0);
    end

    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", int'(status_o), 0);
    chk("R1", int'(prod_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule